// File: doc/BRIEF.md
# Regulator Protection Event Detector

This block sits between the digital outputs of a regulator channel's analog comparators and the rest of the power-management logic. It takes four raw levels: the software enable for the channel, a comparator that is high while the output voltage is below the short-circuit threshold, a current-limit comparator and a die-overtemperature shutdown level. From these it produces qualified single-cycle events and a latched request that turns off the power stage. All timing is counted in ticks of an external time-base strobe, so the real-time windows (20 µs for current limit, 1 ms for the start-up check and for overload) are set by choosing tick counts for a given tick rate.

Each time the channel is enabled, a start-up window opens. On the tick that closes the window, the output comparator is sampled once. If the output is still low, this is a short circuit. If the output has risen, the channel becomes operational and overload supervision is armed. Overload is a separate, continuously debounced condition. The output must stay low for a full debounce period while the channel is running. Short circuit, overload and thermal shutdown all set the disable request. The disable request stays set until software removes the enable. Current limit is a warning only and never turns the channel off.

Top module: `regprot_event_det`

## Requirements
- R1: While the channel is active (enabled, past no trip), `ilim_evt` pulses for exactly one cycle once `ilim_cmp` has been high on CL_TICKS consecutive ticks. Holding the condition longer gives no further pulse. A new pulse needs `ilim_cmp` to go low first.
- R2: `disable_req` rises only because of a short circuit, an overload or thermal shutdown. A current-limit event never sets it.
- R3: If a debounced condition (current limit or overload) goes low before its tick count is reached, its count restarts from zero.
- R4: On the WIN_TICKS-th tick after the enable is seen high, `vout_low` is sampled. If it is high, `short_evt` pulses for one cycle and `disable_req` is set in the same cycle. A shorter enable period gives no short event.
- R5: After a passed start-up check, `vout_low` held high on OVL_TICKS consecutive ticks gives one `ovld_evt` pulse. `disable_req` follows in the next cycle.
- R6: No overload is counted or reported during the start-up window, or while the channel is disabled or tripped.
- R7: `tsd_hot` high while `reg_en` is high sets `disable_req` in the next cycle, in any phase.
- R8: `disable_req` stays set after its cause is gone. It clears in the cycle after `reg_en` is seen low. A later enable starts a fresh start-up window.
- R9: After reset, all four outputs are low.
- R10: Current-limit ticks are not counted, and no `ilim_evt` is produced, while the channel is off or tripped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base strobe, one cycle wide |
| reg_en | input | 1 | Software enable of the channel |
| vout_low | input | 1 | Output below short-circuit threshold |
| ilim_cmp | input | 1 | Current-limit comparator level |
| tsd_hot | input | 1 | Thermal shutdown level |
| ilim_evt | output | 1 | Qualified current-limit pulse |
| short_evt | output | 1 | Start-up short-circuit pulse |
| ovld_evt | output | 1 | Operational overload pulse |
| disable_req | output | 1 | Latched power-stage disable request |

## Verification
The hardest situation to reach is the boundary between the start-up check and overload supervision. A low output that persists through most of the window but clears just before its last tick must produce neither event. The overload count must then start from zero once the channel is running. The bench gets there by holding `vout_low` for WIN_TICKS-1 ticks, releasing it for the closing tick, and then applying OVL_TICKS-1 low ticks. A debouncer that had counted during start-up would fire at that point. Tick-count sweeps just below, at and above each limit cover the other edges.

// File: rtl/regprot_pkg.sv
package regprot_pkg;
  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_CHECK = 2'd1,
    PH_RUN   = 2'd2,
    PH_TRIP  = 2'd3
  } phase_t;

  // True when a counter holding cnt sees the tick that completes lim ticks.
  function automatic logic last_tick(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) == lim;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim);
  endfunction
endpackage

// File: rtl/regprot_debounce.sv
module regprot_debounce
  import regprot_pkg::*;
#(
  parameter int unsigned LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cond,
  output logic hit
);
  localparam int unsigned CW = cnt_width(LIMIT);

  logic [CW-1:0] cnt;
  logic          done;
  logic          qualify;

  assign qualify = cond && tick && !done && last_tick(32'(cnt), LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
      hit  <= 1'b0;
    end else begin
      hit <= qualify;
      if (!cond) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (tick && !done) begin
        if (qualify) done <= 1'b1;
        else         cnt  <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/regprot_window.sv
module regprot_window
  import regprot_pkg::*;
#(
  parameter int unsigned WIN = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic open,
  output logic expire
);
  localparam int unsigned CW = cnt_width(WIN);

  logic [CW-1:0] cnt;

  assign expire = open && tick && last_tick(32'(cnt), WIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!open)            cnt <= '0;
    else if (tick && !expire)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/regprot_event_det.sv
module regprot_event_det
  import regprot_pkg::*;
#(
  parameter int unsigned CL_TICKS  = 20,
  parameter int unsigned WIN_TICKS = 1000,
  parameter int unsigned OVL_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic reg_en,
  input  logic vout_low,
  input  logic ilim_cmp,
  input  logic tsd_hot,
  output logic ilim_evt,
  output logic short_evt,
  output logic ovld_evt,
  output logic disable_req
);
  phase_t phase, phase_nx;
  logic   active;
  logic   win_open;
  logic   win_expire;
  logic   ilim_hit;
  logic   ovl_cond;
  logic   ovl_hit;
  logic   short_now;
  logic   short_q;

  assign active   = (phase == PH_CHECK) || (phase == PH_RUN);
  assign win_open = (phase == PH_CHECK);
  assign ovl_cond = vout_low && (phase == PH_RUN);

  regprot_window #(.WIN(WIN_TICKS)) u_window (
    .clk(clk), .rst_n(rst_n), .tick(tick), .open(win_open), .expire(win_expire)
  );

  regprot_debounce #(.LIMIT(CL_TICKS)) u_ilim_db (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cond(ilim_cmp && active), .hit(ilim_hit)
  );

  regprot_debounce #(.LIMIT(OVL_TICKS)) u_ovl_db (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cond(ovl_cond), .hit(ovl_hit)
  );

  assign short_now = reg_en && win_expire && vout_low;

  always_comb begin
    phase_nx = phase;
    if (!reg_en)              phase_nx = PH_OFF;
    else if (tsd_hot)         phase_nx = PH_TRIP;
    else begin
      unique case (phase)
        PH_OFF:   phase_nx = PH_CHECK;
        PH_CHECK: if (win_expire) phase_nx = vout_low ? PH_TRIP : PH_RUN;
        PH_RUN:   if (ovl_hit) phase_nx = PH_TRIP;
        PH_TRIP:  phase_nx = PH_TRIP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_OFF;
      short_q <= 1'b0;
    end else begin
      phase   <= phase_nx;
      short_q <= short_now;
    end
  end

  assign disable_req = (phase == PH_TRIP);
  assign short_evt   = short_q;
  assign ilim_evt    = ilim_hit && active;
  assign ovld_evt    = ovl_hit && (phase == PH_RUN);
endmodule

module regprot_checker (
  input logic clk,
  input logic rst_n,
  input logic reg_en,
  input logic tsd_hot,
  input logic ilim_evt,
  input logic short_evt,
  input logic ovld_evt,
  input logic disable_req
);
  assert_ilim_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_evt |=> !ilim_evt);

  assert_dis_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disable_req) |-> (short_evt || $past(ovld_evt) || $past(tsd_hot)));

  assert_short_trips_R4: assert property (@(posedge clk) disable iff (!rst_n)
    short_evt |-> disable_req);

  assert_ovld_trips_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovld_evt && reg_en) |=> disable_req);

  assert_ovld_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovld_evt |-> !disable_req);

  assert_tsd_trips_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd_hot && reg_en) |=> disable_req);

  assert_dis_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (disable_req && reg_en) |=> disable_req);

  assert_dis_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en |=> !disable_req);

  assert_ilim_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_evt |-> !disable_req);
endmodule

bind regprot_event_det regprot_checker i_chk (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .tsd_hot(tsd_hot),
  .ilim_evt(ilim_evt), .short_evt(short_evt), .ovld_evt(ovld_evt),
  .disable_req(disable_req)
);

// File: tb/test_regprot_event_det.sv
`timescale 1ns/1ps
module test_regprot_event_det;
  localparam int CL  = 3;
  localparam int WIN = 5;
  localparam int OVL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, reg_en = 1'b0, vout_low = 1'b0, ilim_cmp = 1'b0, tsd_hot = 1'b0;
  logic ilim_evt, short_evt, ovld_evt, disable_req;

  int n_chk = 0, n_fail = 0;
  int n_il = 0, n_sc = 0, n_ov = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  regprot_event_det #(.CL_TICKS(CL), .WIN_TICKS(WIN), .OVL_TICKS(OVL)) i_regprot_event_det (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_en(reg_en), .vout_low(vout_low),
    .ilim_cmp(ilim_cmp), .tsd_hot(tsd_hot), .ilim_evt(ilim_evt), .short_evt(short_evt),
    .ovld_evt(ovld_evt), .disable_req(disable_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic step(input logic t);
    @(negedge clk);
    tick = t;
    @(posedge clk);
    #1;
    if (ilim_evt)  n_il++;
    if (short_evt) n_sc++;
    if (ovld_evt)  n_ov++;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b1);
      step(1'b0);
    end
  endtask

  task automatic zero_counts();
    n_il = 0; n_sc = 0; n_ov = 0;
  endtask

  task automatic bring_up();
    reg_en = 1'b1; vout_low = 1'b0;
    step(1'b0);
    ticks(WIN);
    step(1'b0);
  endtask

  task automatic shut_down();
    reg_en = 1'b0; vout_low = 1'b0; ilim_cmp = 1'b0; tsd_hot = 1'b0;
    step(1'b0);
    step(1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk_eq("R9 outputs", {ilim_evt, short_evt, ovld_evt, disable_req}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0);
    chk_eq("R9 after release", {ilim_evt, short_evt, ovld_evt, disable_req}, 0);

    // R4: short-circuit sweep over tick counts after enable
    for (int k = 0; k <= WIN + 1; k++) begin
      zero_counts();
      reg_en = 1'b1; vout_low = 1'b1;
      step(1'b0);
      ticks(k);
      step(1'b0);
      chk_eq($sformatf("R4 short k=%0d", k), n_sc, (k >= WIN) ? 1 : 0);
      chk_eq($sformatf("R4 disable k=%0d", k), disable_req, (k >= WIN) ? 1 : 0);
      chk_eq($sformatf("R6 no ovld k=%0d", k), n_ov, 0);
      shut_down();
      chk_eq($sformatf("R8 release k=%0d", k), disable_req, 0);
    end

    // R1/R2: current-limit sweep in operation
    for (int n = 0; n <= CL + 2; n++) begin
      zero_counts();
      bring_up();
      ilim_cmp = 1'b1;
      ticks(n);
      step(1'b0);
      ilim_cmp = 1'b0;
      step(1'b0);
      chk_eq($sformatf("R1 ilim n=%0d", n), n_il, (n >= CL) ? 1 : 0);
      chk_eq($sformatf("R2 no disable n=%0d", n), disable_req, 0);
      shut_down();
    end

    // R1: long hold gives one pulse, re-arm after clear
    zero_counts();
    bring_up();
    ilim_cmp = 1'b1; ticks(3 * CL);
    chk_eq("R1 long hold", n_il, 1);
    ilim_cmp = 1'b0; step(1'b0);
    ilim_cmp = 1'b1; ticks(CL); step(1'b0);
    chk_eq("R1 re-arm", n_il, 2);
    // R3: dropout restarts current-limit count
    ilim_cmp = 1'b0; step(1'b0);
    zero_counts();
    ilim_cmp = 1'b1; ticks(CL - 1);
    ilim_cmp = 1'b0; step(1'b0);
    ilim_cmp = 1'b1; ticks(CL - 1); step(1'b0);
    chk_eq("R3 ilim restart", n_il, 0);
    shut_down();

    // R5: overload sweep after passed start-up
    for (int m = 0; m <= OVL + 1; m++) begin
      zero_counts();
      bring_up();
      chk_eq($sformatf("R4 pass m=%0d", m), n_sc, 0);
      vout_low = 1'b1;
      ticks(m);
      step(1'b0);
      chk_eq($sformatf("R5 ovld m=%0d", m), n_ov, (m >= OVL) ? 1 : 0);
      chk_eq($sformatf("R5 disable m=%0d", m), disable_req, (m >= OVL) ? 1 : 0);
      shut_down();
    end

    // R3: overload dropout restarts
    zero_counts();
    bring_up();
    vout_low = 1'b1; ticks(OVL - 1);
    vout_low = 1'b0; step(1'b0);
    vout_low = 1'b1; ticks(OVL - 1); step(1'b0);
    chk_eq("R3 ovld restart", n_ov, 0);
    shut_down();

    // R6: low output during most of the window is not counted as overload
    zero_counts();
    reg_en = 1'b1; vout_low = 1'b1;
    step(1'b0);
    ticks(WIN - 1);
    vout_low = 1'b0; ticks(1); step(1'b0);
    chk_eq("R6 window pass no short", n_sc, 0);
    vout_low = 1'b1; ticks(OVL - 1); step(1'b0);
    chk_eq("R6 no ovld carried from window", n_ov, 0);
    chk_eq("R6 still running", disable_req, 0);
    ticks(1); step(1'b0);
    chk_eq("R5 ovld after full count", n_ov, 1);
    // R6: tripped channel reports no overload; R8 latch
    zero_counts();
    ticks(2 * OVL); step(1'b0);
    chk_eq("R6 no ovld while tripped", n_ov, 0);
    vout_low = 1'b0; ticks(2);
    chk_eq("R8 latched", disable_req, 1);
    shut_down();

    // R7: thermal shutdown
    bring_up();
    tsd_hot = 1'b1; step(1'b0);
    chk_eq("R7 tsd disable", disable_req, 1);
    tsd_hot = 1'b0; step(1'b0);
    chk_eq("R8 hold after tsd", disable_req, 1);
    // R10: no current limit while tripped
    zero_counts();
    ilim_cmp = 1'b1; ticks(2 * CL); step(1'b0);
    chk_eq("R10 no ilim tripped", n_il, 0);
    shut_down();
    // R10: no current limit while off
    ilim_cmp = 1'b1; ticks(2 * CL); step(1'b0);
    chk_eq("R10 no ilim off", n_il, 0);
    ilim_cmp = 1'b0;
    // R7: tsd during start-up window
    reg_en = 1'b1; step(1'b0); ticks(1);
    tsd_hot = 1'b1; step(1'b0);
    chk_eq("R7 tsd in window", disable_req, 1);
    shut_down();
    // R8: fresh start-up after re-enable
    zero_counts();
    bring_up();
    chk_eq("R8 re-enable runs", disable_req, 0);
    chk_eq("R8 re-enable no short", n_sc, 0);
    shut_down();

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule